// File: doc/BRIEF.md
# FM Low-Frequency Modulation Source

This block is the single slow oscillator that every FM channel shares. A phase accumulator advances once per sample strobe by one of eight programmable increments. A 7-bit position is taken from the accumulator just above its fractional bits. That one position drives two outputs. The first is a triangle amplitude-modulation value that rises from 0 to 126 and falls back. The second is a 5-bit phase-modulation step that changes at a quarter of the amplitude rate.

A combinational lookup port turns the current phase-modulation step into a signed frequency offset. It takes two inputs: the upper seven bits of a channel's frequency number and a 3-bit depth. Every set frequency bit adds its own contribution. Contributions are computed from parameter weights, and the 32 steps are folded onto 8 weights. The second quarter of the steps mirrors the first, and the last two quarters negate the first two. A channel AM port scales the amplitude value by a 2-bit channel sensitivity. It gates the result with an operator's AM-enable bit.

Top module: `fm_lfo_mod`

## Requirements
- R1: Synchronous active-high reset clears the accumulator to 0 and disables the oscillator. After reset, am_out, pm_step, lk_offset and op_am_out are all 0.
- R2: A write with cfg_we takes effect on that clock edge. cfg_data bit 3 is the enable and bits 2:0 pick the rate. The default increments for rates 0..7 are 16, 22, 24, 26, 28, 32, 48 and 256.
- R3: While enabled, each sample_stb adds the selected increment to the accumulator. The accumulator is 15 bits wide and wraps modulo 32768. With no strobe and no write, am_out and pm_step hold.
- R4: The position is accumulator bits 14:8. am_out is 2*pos when pos < 64, and 126 - 2*(pos mod 64) otherwise.
- R5: pm_step equals pos >> 2, which gives 32 steps at a quarter of the AM rate.
- R6: While disabled, am_out and pm_step are 0 and strobes leave the accumulator untouched. Re-enabling resumes from the held value.
- R7: lk_offset starts from the sum, over each set bit b of lk_fnum, of ((W[i] * M[lk_pms]) << b) >> 3. The defaults are W[i] = i and M = {0,1,2,3,4,6,8,12} for depths 0..7. A frequency number of 0 gives 0.
- R8: With q = pm_step[4:3] and s = pm_step[2:0], the weight index is i = s when q[0] = 0 and i = 7 - s when q[0] = 1. The sum is negated when q[1] = 1.
- R9: op_am_out is am_out shifted right by 7, 3, 1 or 0 for ch_ams values 0, 1, 2 and 3.
- R10: op_am_out is 0 whenever op_am_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_data | input | 4 | Bit 3 enable, bits 2:0 rate select |
| sample_stb | input | 1 | One pulse per output sample |
| am_out | output | 7 | Triangle amplitude value |
| pm_step | output | 5 | Phase-modulation step |
| lk_fnum | input | 7 | Upper frequency-number bits of the channel being looked up |
| lk_pms | input | 3 | Phase-modulation depth of that channel |
| lk_offset | output | 12 | Signed frequency offset |
| ch_ams | input | 2 | Channel amplitude sensitivity |
| op_am_en | input | 1 | Operator AM-enable bit |
| op_am_out | output | 7 | Scaled and gated AM for the operator |

## Verification
The bench builds the block with its default parameters. Rate 7, with an increment of 256, moves the position by exactly one per strobe. That takes the whole triangle and all 32 modulation steps into reach in 128 strobes, including both folding boundaries of the lookup. Rate 3, with an increment of 26, exercises fractional accumulation. It reaches a full accumulator wrap in about 1300 strobes.

// File: rtl/fm_lfo_pkg.sv
package fm_lfo_pkg;

    localparam int POS_W     = 7;
    localparam int AM_W      = 7;
    localparam int PM_W      = 5;
    localparam int FNUM_W    = 7;
    localparam int PMS_W     = 3;
    localparam int AMS_W     = 2;
    localparam int RATE_W    = 3;
    localparam int NUM_RATES = 1 << RATE_W;
    localparam int INC_FLD   = 16;
    localparam int WT_FLD    = 4;
    localparam int MUL_FLD   = 5;
    localparam int SH_FLD    = 3;

    typedef struct packed {
        logic              en;
        logic [RATE_W-1:0] rate;
    } lfo_cfg_t;

    typedef struct packed {
        logic [AM_W-1:0] am;
        logic [PM_W-1:0] pm;
    } lfo_wave_t;

    // triangle: rising for the lower half of the position range, falling after
    function automatic logic [AM_W-1:0] tri_am(input logic [POS_W-1:0] p);
        logic [AM_W-1:0] dbl;
        dbl = {p[POS_W-2:0], 1'b0};
        return p[POS_W-1] ? (7'd126 - dbl) : dbl;
    endfunction

    function automatic logic [PM_W-1:0] pm_of(input logic [POS_W-1:0] p);
        return p[POS_W-1:2];
    endfunction

endpackage

// File: rtl/fm_lfo_phase_acc.sv
module fm_lfo_phase_acc
    import fm_lfo_pkg::*;
#(
    parameter int FRAC_SH = 8,
    parameter logic [NUM_RATES*INC_FLD-1:0] RATE_INC = {
        16'd256, 16'd48, 16'd32, 16'd28, 16'd26, 16'd24, 16'd22, 16'd16}
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [3:0]       cfg_data,
    input  logic             sample_stb,
    output logic             lfo_en,
    output logic [POS_W-1:0] pos
);
    localparam int CNT_W = FRAC_SH + POS_W;
    localparam int SUM_W = CNT_W + INC_FLD;

    lfo_cfg_t          cfg_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [INC_FLD-1:0] inc_sel;
    logic [SUM_W-1:0]  sum;

    assign inc_sel = RATE_INC[cfg_q.rate*INC_FLD +: INC_FLD];
    assign sum     = {{INC_FLD{1'b0}}, cnt_q} + {{CNT_W{1'b0}}, inc_sel};

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            cnt_q <= '0;
        end else begin
            if (cfg_we) begin
                cfg_q.en   <= cfg_data[3];
                cfg_q.rate <= cfg_data[2:0];
            end
            if (sample_stb && cfg_q.en) begin
                cnt_q <= sum[CNT_W-1:0];
            end
        end
    end

    assign lfo_en = cfg_q.en;
    assign pos    = cnt_q[CNT_W-1:FRAC_SH];

endmodule

// File: rtl/fm_lfo_wave.sv
module fm_lfo_wave
    import fm_lfo_pkg::*;
(
    input  logic             lfo_en,
    input  logic [POS_W-1:0] pos,
    output lfo_wave_t        wave
);
    always_comb begin
        if (lfo_en) begin
            wave.am = tri_am(pos);
            wave.pm = pm_of(pos);
        end else begin
            wave = '0;
        end
    end
endmodule

// File: rtl/fm_lfo_pm_lookup.sv
module fm_lfo_pm_lookup
    import fm_lfo_pkg::*;
#(
    parameter int OFS_W    = 12,
    parameter int SCALE_SH = 3,
    parameter logic [8*WT_FLD-1:0] STEP_WT = {
        4'd7, 4'd6, 4'd5, 4'd4, 4'd3, 4'd2, 4'd1, 4'd0},
    parameter logic [8*MUL_FLD-1:0] DEPTH_MUL = {
        5'd12, 5'd8, 5'd6, 5'd4, 5'd3, 5'd2, 5'd1, 5'd0}
) (
    input  logic [PM_W-1:0]         pm_step,
    input  logic [FNUM_W-1:0]       fnum,
    input  logic [PMS_W-1:0]        pms,
    output logic signed [OFS_W-1:0] offset
);
    localparam int ACC_W = 16;
    localparam int PRD_W = WT_FLD + MUL_FLD;

    logic [2:0]        idx;
    logic              neg;
    logic [WT_FLD-1:0] wt;
    logic [MUL_FLD-1:0] mul;
    logic [PRD_W-1:0]  prod;
    logic [ACC_W-1:0]  part [FNUM_W];
    logic [ACC_W-1:0]  mag;
    logic [ACC_W-1:0]  sval;

    // second quarter mirrors the first, upper half negates the lower
    assign idx  = pm_step[3] ? ~pm_step[2:0] : pm_step[2:0];
    assign neg  = pm_step[4];
    assign wt   = STEP_WT[idx*WT_FLD +: WT_FLD];
    assign mul  = DEPTH_MUL[pms*MUL_FLD +: MUL_FLD];
    assign prod = {{MUL_FLD{1'b0}}, wt} * {{WT_FLD{1'b0}}, mul};

    for (genvar b = 0; b < FNUM_W; b++) begin : g_bit
        logic [ACC_W-1:0] wide;
        assign wide    = {{(ACC_W-PRD_W){1'b0}}, prod} << b;
        assign part[b] = fnum[b] ? (wide >> SCALE_SH) : '0;
    end

    always_comb begin
        mag = '0;
        for (int b = 0; b < FNUM_W; b++) begin
            mag = mag + part[b];
        end
    end

    assign sval   = neg ? (16'd0 - mag) : mag;
    assign offset = sval[OFS_W-1:0];

endmodule

// File: rtl/fm_lfo_am_scale.sv
module fm_lfo_am_scale
    import fm_lfo_pkg::*;
#(
    parameter logic [4*SH_FLD-1:0] AMS_SHIFT = {3'd0, 3'd1, 3'd3, 3'd7}
) (
    input  logic [AM_W-1:0]  am_in,
    input  logic [AMS_W-1:0] ams,
    input  logic             op_en,
    output logic [AM_W-1:0]  am_out
);
    logic [SH_FLD-1:0] sh;
    assign sh     = AMS_SHIFT[ams*SH_FLD +: SH_FLD];
    assign am_out = op_en ? (am_in >> sh) : '0;
endmodule

// File: rtl/fm_lfo_mod.sv
module fm_lfo_mod
    import fm_lfo_pkg::*;
#(
    parameter int FRAC_SH  = 8,
    parameter int OFS_W    = 12,
    parameter int SCALE_SH = 3,
    parameter logic [NUM_RATES*INC_FLD-1:0] RATE_INC = {
        16'd256, 16'd48, 16'd32, 16'd28, 16'd26, 16'd24, 16'd22, 16'd16},
    parameter logic [8*WT_FLD-1:0] STEP_WT = {
        4'd7, 4'd6, 4'd5, 4'd4, 4'd3, 4'd2, 4'd1, 4'd0},
    parameter logic [8*MUL_FLD-1:0] DEPTH_MUL = {
        5'd12, 5'd8, 5'd6, 5'd4, 5'd3, 5'd2, 5'd1, 5'd0},
    parameter logic [4*SH_FLD-1:0] AMS_SHIFT = {3'd0, 3'd1, 3'd3, 3'd7}
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_we,
    input  logic [3:0]              cfg_data,
    input  logic                    sample_stb,
    output logic [6:0]              am_out,
    output logic [4:0]              pm_step,
    input  logic [6:0]              lk_fnum,
    input  logic [2:0]              lk_pms,
    output logic signed [OFS_W-1:0] lk_offset,
    input  logic [1:0]              ch_ams,
    input  logic                    op_am_en,
    output logic [6:0]              op_am_out
);
    logic             lfo_en;
    logic [POS_W-1:0] pos;
    lfo_wave_t        wave;

    fm_lfo_phase_acc #(
        .FRAC_SH (FRAC_SH),
        .RATE_INC(RATE_INC)
    ) u_acc (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_data  (cfg_data),
        .sample_stb(sample_stb),
        .lfo_en    (lfo_en),
        .pos       (pos)
    );

    fm_lfo_wave u_wave (
        .lfo_en(lfo_en),
        .pos   (pos),
        .wave  (wave)
    );

    assign am_out  = wave.am;
    assign pm_step = wave.pm;

    fm_lfo_pm_lookup #(
        .OFS_W    (OFS_W),
        .SCALE_SH (SCALE_SH),
        .STEP_WT  (STEP_WT),
        .DEPTH_MUL(DEPTH_MUL)
    ) u_lookup (
        .pm_step(wave.pm),
        .fnum   (lk_fnum),
        .pms    (lk_pms),
        .offset (lk_offset)
    );

    fm_lfo_am_scale #(
        .AMS_SHIFT(AMS_SHIFT)
    ) u_ams (
        .am_in (wave.am),
        .ams   (ch_ams),
        .op_en (op_am_en),
        .am_out(op_am_out)
    );

endmodule

// File: rtl/fm_lfo_mod_chk.sv
module fm_lfo_mod_chk #(
    parameter int OFS_W = 12
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    cfg_we,
    input logic                    sample_stb,
    input logic                    lfo_en,
    input logic [6:0]              am_out,
    input logic [4:0]              pm_step,
    input logic [6:0]              lk_fnum,
    input logic signed [OFS_W-1:0] lk_offset,
    input logic                    op_am_en,
    input logic [6:0]              op_am_out
);
    p_am_shape_r4: assert property (@(posedge clk) disable iff (rst)
        (am_out[0] == 1'b0) && (am_out <= 7'd126));

    p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!sample_stb && !cfg_we) |=> ($stable(am_out) && $stable(pm_step)));

    p_off_zero_r6: assert property (@(posedge clk) disable iff (rst)
        !lfo_en |-> (am_out == 7'd0 && pm_step == 5'd0));

    p_fnum_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (lk_fnum == 7'd0) |-> (lk_offset == '0));

    p_gate_r10: assert property (@(posedge clk) disable iff (rst)
        !op_am_en |-> (op_am_out == 7'd0));

    p_scale_bound_r9: assert property (@(posedge clk) disable iff (rst)
        op_am_out <= am_out);
endmodule

bind fm_lfo_mod fm_lfo_mod_chk #(.OFS_W(OFS_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .sample_stb(sample_stb),
    .lfo_en    (lfo_en),
    .am_out    (am_out),
    .pm_step   (pm_step),
    .lk_fnum   (lk_fnum),
    .lk_offset (lk_offset),
    .op_am_en  (op_am_en),
    .op_am_out (op_am_out)
);

// File: tb/fm_lfo_mod_tb.sv
module fm_lfo_mod_tb;
    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_we = 1'b0;
    logic [3:0]        cfg_data = '0;
    logic              sample_stb = 1'b0;
    logic [6:0]        am_out;
    logic [4:0]        pm_step;
    logic [6:0]        lk_fnum = '0;
    logic [2:0]        lk_pms = '0;
    logic signed [11:0] lk_offset;
    logic [1:0]        ch_ams = '0;
    logic              op_am_en = 1'b0;
    logic [6:0]        op_am_out;

    int n_chk = 0;
    int n_bad = 0;
    int cnt_m = 0;
    bit en_m = 0;
    int rate_m = 0;
    bit done = 0;

    int inc_tab [8] = '{16, 22, 24, 26, 28, 32, 48, 256};
    int mul_tab [8] = '{0, 1, 2, 3, 4, 6, 8, 12};
    int sh_tab  [4] = '{7, 3, 1, 0};

    always #2.5 clk = ~clk;

    fm_lfo_mod u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_data(cfg_data),
        .sample_stb(sample_stb), .am_out(am_out), .pm_step(pm_step),
        .lk_fnum(lk_fnum), .lk_pms(lk_pms), .lk_offset(lk_offset),
        .ch_ams(ch_ams), .op_am_en(op_am_en), .op_am_out(op_am_out)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int m_pos();
        return (cnt_m >> 8) & 127;
    endfunction

    function automatic int m_am();
        int p = m_pos();
        if (!en_m) return 0;
        return (p < 64) ? 2 * p : 126 - 2 * (p & 63);
    endfunction

    function automatic int m_pm();
        return en_m ? (m_pos() >> 2) : 0;
    endfunction

    function automatic int m_ofs(input int fn, input int pms);
        int st = m_pm();
        int i = ((st >> 3) & 1) ? ((st & 7) ^ 7) : (st & 7);
        int sum = 0;
        for (int b = 0; b < 7; b++)
            if ((fn >> b) & 1) sum += ((i * mul_tab[pms]) << b) >> 3;
        return ((st >> 4) & 1) ? -sum : sum;
    endfunction

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        cnt_m = 0; en_m = 0; rate_m = 0;
    endtask

    task automatic write_cfg(input logic [3:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_data = v;
        @(negedge clk); cfg_we = 1'b0;
        en_m = v[3]; rate_m = int'(v[2:0]);
    endtask

    task automatic strobe();
        @(negedge clk); sample_stb = 1'b1;
        @(negedge clk); sample_stb = 1'b0;
        if (en_m) cnt_m = (cnt_m + inc_tab[rate_m]) % 32768;
    endtask

    task automatic t_reset();
        do_reset();
        lk_fnum = 7'h7F; lk_pms = 3'd7; op_am_en = 1'b1; ch_ams = 2'd3;
        #1;
        check("R1 am", int'(am_out), 0);
        check("R1 pm", int'(pm_step), 0);
        check("R1 offset", int'(lk_offset), 0);
        check("R1 op_am", int'(op_am_out), 0);
    endtask

    task automatic t_triangle();
        do_reset();
        write_cfg(4'hF);
        for (int k = 0; k < 130; k++) begin
            check("R4 am", int'(am_out), m_am());
            check("R5 pm", int'(pm_step), m_pm());
            strobe();
        end
    endtask

    task automatic t_rate();
        do_reset();
        write_cfg(4'hB);
        for (int k = 0; k < 1300; k++) begin
            strobe();
            check("R3 am", int'(am_out), m_am());
            check("R3 pm", int'(pm_step), m_pm());
        end
    endtask

    task automatic t_hold();
        int a;
        do_reset();
        write_cfg(4'hF);
        for (int k = 0; k < 37; k++) strobe();
        a = m_am();
        for (int k = 0; k < 8; k++) @(negedge clk);
        check("R3 hold am", int'(am_out), a);
        check("R3 hold pm", int'(pm_step), m_pm());
    endtask

    task automatic t_disable();
        do_reset();
        write_cfg(4'hF);
        for (int k = 0; k < 10; k++) strobe();
        check("R2 enabled am", int'(am_out), 20);
        write_cfg(4'h7);
        check("R6 off am", int'(am_out), 0);
        check("R6 off pm", int'(pm_step), 0);
        for (int k = 0; k < 5; k++) strobe();
        check("R6 still off", int'(am_out), 0);
        write_cfg(4'hF);
        check("R6 resumed am", int'(am_out), 20);
        check("R6 resumed pm", int'(pm_step), 2);
    endtask

    task automatic t_lookup();
        int fns [4] = '{127, 21, 64, 0};
        int pss [4] = '{7, 3, 5, 6};
        do_reset();
        write_cfg(4'hF);
        for (int k = 0; k < 128; k++) begin
            if ((k & 3) == 0) begin
                for (int c = 0; c < 4; c++) begin
                    lk_fnum = 7'(fns[c]); lk_pms = 3'(pss[c]);
                    #1;
                    check((m_pm() >= 8) ? "R8 offset" : "R7 offset",
                          int'(lk_offset), m_ofs(fns[c], pss[c]));
                end
            end
            strobe();
        end
        lk_fnum = 7'h7F; lk_pms = 3'd0; #1;
        check("R7 depth0", int'(lk_offset), 0);
    endtask

    task automatic t_ams();
        do_reset();
        write_cfg(4'hF);
        for (int k = 0; k < 50; k++) strobe();
        for (int a = 0; a < 4; a++) begin
            for (int e = 0; e < 2; e++) begin
                ch_ams = 2'(a); op_am_en = e[0]; #1;
                if (e == 1) check("R9 scaled", int'(op_am_out), 100 >> sh_tab[a]);
                else        check("R10 gated", int'(op_am_out), 0);
            end
        end
        for (int k = 0; k < 13; k++) strobe();
        ch_ams = 2'd1; op_am_en = 1'b1; #1;
        check("R9 peak", int'(op_am_out), 126 >> 3);
    endtask

    initial begin
        t_reset();
        t_triangle();
        t_rate();
        t_hold();
        t_disable();
        t_lookup();
        t_ams();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule